// File: doc/BRIEF.md
# USB Device Command Interpreter

This block is the command front end of a USB device controller's protocol engine. Software does not reach the engine's registers directly. It sends 32-bit words on a command stream. Bits 15:8 of each word choose the phase: a command phase names an operation, a write phase supplies one argument byte, and a read phase fetches one result byte. Read results leave on a separate result stream. Two sticky flags support polling or interrupt-driven software. One flag says that a command or write phase has been taken. The other is raised by changes in device status.

Inside, the block holds the device address and enable bit, the configured bit, the mode byte, an 11-bit frame counter, the device status with its change bits, the latched error status, and the last error code. Bus events arrive as plain level and strobe inputs. Packet handling and endpoint buffers are outside this block.

Top module: `usb_cmd_engine`

The command stream uses a valid/ready handshake. A word is taken on a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low while a read result waits unclaimed, so software must take each result before it sends the next word. The result stream also uses a valid/ready handshake. `rd_data` holds steady while `rd_valid` is high and `rd_ready` is low.

## Requirements
- R1: Bits 15:8 of `cmd_word` select the phase: 0x05 command, 0x01 write, 0x02 read. Bits 23:16 carry the operation code for command and read phases, and the data byte for write phases. A word with any other phase value is taken but has no effect: no flag is raised and no state changes, including a pending command.
- R2: `cc_empty` is set on the edge that takes a command or write phase. Writing 1 to `int_clr[0]` clears it. If a set and a clear happen in the same cycle, the set wins.
- R3: A read phase sets `rd_valid` on the edge that takes it, with the result in `rd_data`. `rd_valid` stays high, with `rd_data` stable, until a cycle with `rd_ready` high. `cmd_ready` equals the inverse of `rd_valid`.
- R4: Operation 0xD0 followed by a write byte sets `dev_addr` to bits 6:0 of the byte and `dev_en` to bit 7.
- R5: Operation 0xD8 followed by a write byte sets `configured` from bit 0 of the byte. Operation 0xF3 followed by a write byte loads `mode` with the whole byte.
- R6: Operation 0xFD returns 0x0F on its first read phase and 0xA5 on its second while `usb_clk_on` is high. While `usb_clk_on` is low it returns 0x00 on both reads.
- R7: Operation 0xF5 returns the low byte of the frame counter on the first read. The second read returns the high bits, zero-extended, as they stood at the first read. Each `frame_tick` pulse adds one to the counter.
- R8: The device status byte (operation 0xFE) has these bits: bit 0 connected (`link_up`), bit 1 connect changed, bit 2 suspended (`suspend_in`), bit 3 suspend changed, bit 4 bus reset seen. A change of `link_up` or `suspend_in`, or a `bus_reset` pulse, sets `dev_int`. Writing 1 to `int_clr[1]` clears `dev_int`.
- R9: Reading the device status returns bits 1, 3 and 4 as they were, then clears them. An event in the same cycle as the read stays latched.
- R10: The error status byte (operation 0xFB) collects `err_evt` pulses with one bit per error: bit 0 PID, bit 1 unexpected packet, bit 2 data CRC, bit 3 timeout, bit 4 end of packet, bit 5 overrun, bit 6 bit stuffing, bit 7 data toggle. Reading it returns the byte and clears it.
- R11: Operation 0xFF returns the error code in bits 3:0 and an error-active bit in bit 4. The code is 1 plus the index of the lowest set bit of the most recent nonzero `err_evt`. The byte is 0x00 until the first error.
- R12: Some read phases return 0x00, still set `rd_valid`, and change no state: one with no pending command, one whose code differs from the pending command, or one whose pending command has no result. The pending command stays pending after such a read.
- R13: A write phase with no pending command, or with a pending command that takes no argument, changes no device register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command word valid |
| cmd_ready | output | 1 | Command word can be taken |
| cmd_word | input | 32 | Phase in bits 15:8, code or data in bits 23:16 |
| rd_valid | output | 1 | Read result waiting (data-full flag) |
| rd_ready | input | 1 | Software takes the read result |
| rd_data | output | 8 | Read result byte |
| cc_empty | output | 1 | Command or write phase taken |
| dev_int | output | 1 | Device status change flag |
| int_clr | input | 2 | Flag clear: bit 0 clears cc_empty, bit 1 clears dev_int |
| usb_clk_on | input | 1 | USB clock running |
| frame_tick | input | 1 | Start-of-frame pulse |
| link_up | input | 1 | Connection level |
| suspend_in | input | 1 | Suspend level |
| bus_reset | input | 1 | Bus reset pulse |
| err_evt | input | 8 | Error event pulses, one bit per error kind |
| dev_addr | output | 7 | Device address |
| dev_en | output | 1 | Device enable |
| configured | output | 1 | Non-control endpoints enabled |
| mode | output | 8 | Mode byte |

## Verification
The hardest case to reach from the ports is a wide read whose two halves see different frame counter values. The bench sets the counter to 0x2A7 and takes the low byte. It then sends 256 more frame pulses before the second read, so a design without the snapshot would return 0x03 where 0x02 is expected. The bench also sends a read with the wrong code, and a word with an unused phase value, between a command and its data phases. These check that the pending command survives unharmed. Device status is read twice in a row to show that the change bits are cleared while the level bits remain.

// File: rtl/usb_cmd_pkg.sv
package usb_cmd_pkg;
  localparam logic [7:0] PH_WRITE = 8'h01;
  localparam logic [7:0] PH_READ  = 8'h02;
  localparam logic [7:0] PH_CMD   = 8'h05;

  localparam logic [7:0] OP_SET_ADDR = 8'hD0;
  localparam logic [7:0] OP_CONFIG   = 8'hD8;
  localparam logic [7:0] OP_SET_MODE = 8'hF3;
  localparam logic [7:0] OP_FRAME    = 8'hF5;
  localparam logic [7:0] OP_ERR_STAT = 8'hFB;
  localparam logic [7:0] OP_TEST     = 8'hFD;
  localparam logic [7:0] OP_DEV_STAT = 8'hFE;
  localparam logic [7:0] OP_ERR_CODE = 8'hFF;

  function automatic logic op_takes_arg(input logic [7:0] op);
    return (op == OP_SET_ADDR) || (op == OP_CONFIG) || (op == OP_SET_MODE);
  endfunction

  function automatic logic op_has_result(input logic [7:0] op);
    return (op == OP_FRAME) || (op == OP_ERR_STAT) || (op == OP_TEST) ||
           (op == OP_DEV_STAT) || (op == OP_ERR_CODE);
  endfunction

  function automatic logic op_is_wide(input logic [7:0] op);
    return (op == OP_FRAME) || (op == OP_TEST);
  endfunction

  // 1 + index of lowest set bit, 0 when none
  function automatic logic [3:0] lowest_err(input logic [7:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) r = 4'(i + 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/usb_cmd_seq.sv
module usb_cmd_seq
  import usb_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic [31:0] word,
  output logic        wr_stb,
  output logic        rd_stb,
  output logic        rd_bad,
  output logic        cc_set,
  output logic [7:0]  op,
  output logic [7:0]  arg,
  output logic        rd_hi
);
  logic [7:0] phase;
  logic       pend_v;
  logic [7:0] pend_op;
  logic       hi_q;

  assign phase = word[15:8];
  assign arg   = word[23:16];
  assign op    = pend_op;
  assign rd_hi = hi_q;

  assign wr_stb = accept && (phase == PH_WRITE) && pend_v && op_takes_arg(pend_op);
  assign rd_stb = accept && (phase == PH_READ) && pend_v && (arg == pend_op) &&
                  op_has_result(pend_op);
  assign rd_bad = accept && (phase == PH_READ) && !rd_stb;
  assign cc_set = accept && ((phase == PH_CMD) || (phase == PH_WRITE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_v  <= 1'b0;
      pend_op <= '0;
      hi_q    <= 1'b0;
    end else if (accept && (phase == PH_CMD)) begin
      pend_v  <= 1'b1;
      pend_op <= arg;
      hi_q    <= 1'b0;
    end else if (wr_stb) begin
      pend_v <= 1'b0;
    end else if (rd_stb) begin
      if (op_is_wide(pend_op) && !hi_q) begin
        hi_q <= 1'b1;
      end else begin
        pend_v <= 1'b0;
        hi_q   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/usb_dev_cfg.sv
module usb_dev_cfg
  import usb_cmd_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [7:0]        op,
  input  logic [7:0]        arg,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dev_en,
  output logic              configured,
  output logic [7:0]        mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dev_addr   <= '0;
      dev_en     <= 1'b0;
      configured <= 1'b0;
      mode       <= '0;
    end else if (wr_stb) begin
      case (op)
        OP_SET_ADDR: begin
          dev_addr <= arg[ADDR_W-1:0];
          dev_en   <= arg[ADDR_W];
        end
        OP_CONFIG:   configured <= arg[0];
        OP_SET_MODE: mode <= arg;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usb_evt_status.sv
module usb_evt_status
  import usb_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       suspend_in,
  input  logic       bus_reset,
  input  logic [7:0] err_evt,
  input  logic       clr_dev,
  input  logic       clr_err,
  output logic [7:0] dev_stat,
  output logic [7:0] err_stat,
  output logic [7:0] err_code,
  output logic       dev_evt
);
  logic       link_q, susp_q, con_chg, sus_chg, rst_seen;
  logic       con_evt, sus_evt;
  logic [7:0] err_q;
  logic [3:0] code_q;
  logic       active_q;

  assign con_evt = link_up != link_q;
  assign sus_evt = suspend_in != susp_q;
  assign dev_evt = con_evt || sus_evt || bus_reset;

  assign dev_stat = {3'b000, rst_seen, sus_chg, susp_q, con_chg, link_q};
  assign err_stat = err_q;
  assign err_code = {3'b000, active_q, code_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q   <= 1'b0;
      susp_q   <= 1'b0;
      con_chg  <= 1'b0;
      sus_chg  <= 1'b0;
      rst_seen <= 1'b0;
      err_q    <= '0;
      code_q   <= '0;
      active_q <= 1'b0;
    end else begin
      link_q   <= link_up;
      susp_q   <= suspend_in;
      con_chg  <= con_evt   || (con_chg  && !clr_dev);
      sus_chg  <= sus_evt   || (sus_chg  && !clr_dev);
      rst_seen <= bus_reset || (rst_seen && !clr_dev);
      err_q    <= err_evt | (clr_err ? 8'h00 : err_q);
      if (|err_evt) begin
        code_q   <= lowest_err(err_evt);
        active_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/usb_cmd_engine.sv
module usb_cmd_engine
  import usb_cmd_pkg::*;
#(
  parameter int          FRAME_W   = 11,
  parameter logic [15:0] TEST_WORD = 16'hA50F
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [31:0] cmd_word,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic        cc_empty,
  output logic        dev_int,
  input  logic [1:0]  int_clr,
  input  logic        usb_clk_on,
  input  logic        frame_tick,
  input  logic        link_up,
  input  logic        suspend_in,
  input  logic        bus_reset,
  input  logic [7:0]  err_evt,
  output logic [6:0]  dev_addr,
  output logic        dev_en,
  output logic        configured,
  output logic [7:0]  mode
);
  localparam int ADDR_W = 7;

  logic               accept, wr_stb, rd_stb, rd_bad, cc_set, rd_hi, dev_evt;
  logic [7:0]         op, arg, rd_byte, dev_stat, err_stat, err_code;
  logic [FRAME_W-1:0] frame_q;
  logic [7:0]         frame_hi_q;

  assign cmd_ready = !rd_valid;
  assign accept    = cmd_valid && cmd_ready;

  usb_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .accept(accept), .word(cmd_word),
    .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_bad(rd_bad), .cc_set(cc_set),
    .op(op), .arg(arg), .rd_hi(rd_hi)
  );

  usb_dev_cfg #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .op(op), .arg(arg),
    .dev_addr(dev_addr), .dev_en(dev_en), .configured(configured), .mode(mode)
  );

  usb_evt_status u_evt (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .suspend_in(suspend_in),
    .bus_reset(bus_reset), .err_evt(err_evt),
    .clr_dev(rd_stb && (op == OP_DEV_STAT)),
    .clr_err(rd_stb && (op == OP_ERR_STAT)),
    .dev_stat(dev_stat), .err_stat(err_stat), .err_code(err_code),
    .dev_evt(dev_evt)
  );

  always_comb begin
    rd_byte = '0;
    if (rd_stb) begin
      case (op)
        OP_TEST:     rd_byte = !usb_clk_on ? 8'h00 :
                               (rd_hi ? TEST_WORD[15:8] : TEST_WORD[7:0]);
        OP_FRAME:    rd_byte = rd_hi ? frame_hi_q : frame_q[7:0];
        OP_DEV_STAT: rd_byte = dev_stat;
        OP_ERR_STAT: rd_byte = err_stat;
        OP_ERR_CODE: rd_byte = err_code;
        default:     rd_byte = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q    <= '0;
      frame_hi_q <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      cc_empty   <= 1'b0;
      dev_int    <= 1'b0;
    end else begin
      if (frame_tick) frame_q <= frame_q + 1'b1;
      if (rd_stb && (op == OP_FRAME) && !rd_hi) frame_hi_q <= 8'(frame_q >> 8);
      if (rd_stb || rd_bad) begin
        rd_valid <= 1'b1;
        rd_data  <= rd_byte;
      end else if (rd_ready) begin
        rd_valid <= 1'b0;
      end
      cc_empty <= cc_set  || (cc_empty && !int_clr[0]);
      dev_int  <= dev_evt || (dev_int  && !int_clr[1]);
    end
  end
endmodule

// File: rtl/usb_cmd_engine_chk.sv
module usb_cmd_engine_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        cmd_ready,
  input logic [31:0] cmd_word,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic [7:0]  rd_data,
  input logic        cc_empty,
  input logic        dev_int,
  input logic [1:0]  int_clr,
  input logic        bus_reset,
  input logic        dev_en,
  input logic [6:0]  dev_addr,
  input logic        configured
);
  logic       acc;
  logic [7:0] ph;
  assign acc = cmd_valid && cmd_ready;
  assign ph  = cmd_word[15:8];

  // R3
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R3
  rd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ph == 8'h02 |=> rd_valid);

  // R2
  cc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (ph == 8'h05 || ph == 8'h01) |=> cc_empty);

  // R8
  rst_int_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> dev_int);

  // R1
  bad_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && ph != 8'h01 && ph != 8'h02 && ph != 8'h05 |=>
      !$rose(cc_empty) && $stable(dev_addr) && $stable(configured));

  // R4
  en_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dev_en) |-> $past(acc && ph == 8'h01));
endmodule

bind usb_cmd_engine usb_cmd_engine_chk u_chk (.*);

// File: tb/usb_cmd_engine_test.sv
`timescale 1ns/1ps
module usb_cmd_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [31:0] cmd_word = '0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [7:0]  rd_data;
  logic        cc_empty, dev_int;
  logic [1:0]  int_clr = '0;
  logic        usb_clk_on = 1'b1;
  logic        frame_tick = 1'b0;
  logic        link_up = 1'b0;
  logic        suspend_in = 1'b0;
  logic        bus_reset = 1'b0;
  logic [7:0]  err_evt = '0;
  logic [6:0]  dev_addr;
  logic        dev_en, configured;
  logic [7:0]  mode;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  usb_cmd_engine uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_word  = w;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c);
    send({8'h00, c, 8'h05, 8'h00});
  endtask

  task automatic wr(input logic [7:0] b);
    send({8'h00, b, 8'h01, 8'h00});
  endtask

  task automatic rd(input logic [7:0] c, input logic [7:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    send({8'h00, c, 8'h02, 8'h00});
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || rd_valid) @(negedge clk);
  endtask

  task automatic clr(input logic [1:0] m);
    @(negedge clk);
    int_clr = m;
    @(negedge clk);
    int_clr = '0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rd_ready) begin
        rd_ready = 1'b0;
      end else if (rd_valid) begin
        if (exp_q.size() == 0) begin
          checks++;
          errors++;
          $display("FAIL R3: unexpected result %0h expected none", rd_data);
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
        rd_ready = 1'b1;
      end
    end
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R3 reset ready", cmd_ready, 1);
    check("R3 reset rd_valid", rd_valid, 0);
    check("R2 reset cc_empty", cc_empty, 0);
    check("R8 reset dev_int", dev_int, 0);
    check("R4 reset addr", {dev_en, dev_addr}, 0);
    check("R5 reset cfg", {configured, mode}, 0);

    cmd(8'hD0);
    check("R2 cc set", cc_empty, 1);
    clr(2'b01);
    check("R2 cc clear", cc_empty, 0);
    wr(8'h85);
    check("R4 addr", dev_addr, 7'h05);
    check("R4 en", dev_en, 1);
    check("R2 cc on write", cc_empty, 1);
    wr(8'h33);
    check("R13 stray write", {dev_en, dev_addr}, 8'h85);

    cmd(8'hD8); wr(8'h01);
    check("R5 configured", configured, 1);
    cmd(8'hF3); wr(8'h6C);
    check("R5 mode", mode, 8'h6C);
    cmd(8'hFE); wr(8'h11);
    check("R13 write to no-arg op", {configured, mode}, 9'h16C);

    cmd(8'hD0);
    clr(2'b01);
    send({8'h00, 8'h22, 8'h07, 8'h00});
    check("R1 bad phase no flag", cc_empty, 0);
    check("R1 bad phase no state", dev_addr, 7'h05);
    wr(8'h12);
    check("R1 pending kept addr", {dev_en, dev_addr}, 8'h12);

    cmd(8'hFD);
    rd(8'hFE, 8'h00, "R12 mismatched read");
    rd(8'hFD, 8'h0F, "R6 test low");
    rd(8'hFD, 8'hA5, "R6 test high");
    drain();
    usb_clk_on = 1'b0;
    cmd(8'hFD);
    rd(8'hFD, 8'h00, "R6 clock off low");
    rd(8'hFD, 8'h00, "R6 clock off high");
    drain();
    usb_clk_on = 1'b1;
    rd(8'hFB, 8'h00, "R12 no pending read");
    drain();

    @(negedge clk);
    frame_tick = 1'b1;
    repeat (679) @(negedge clk);
    frame_tick = 1'b0;
    cmd(8'hF5);
    rd(8'hF5, 8'hA7, "R7 frame low");
    drain();
    @(negedge clk);
    frame_tick = 1'b1;
    repeat (256) @(negedge clk);
    frame_tick = 1'b0;
    rd(8'hF5, 8'h02, "R7 frame high snapshot");
    drain();

    @(negedge clk);
    link_up = 1'b1;
    @(negedge clk);
    check("R8 connect raises int", dev_int, 1);
    cmd(8'hFE);
    rd(8'hFE, 8'h03, "R8 status connect");
    drain();
    cmd(8'hFE);
    rd(8'hFE, 8'h01, "R9 change cleared");
    drain();
    clr(2'b10);
    check("R8 int clear", dev_int, 0);
    @(negedge clk);
    suspend_in = 1'b1;
    bus_reset  = 1'b1;
    @(negedge clk);
    bus_reset  = 1'b0;
    check("R8 suspend raises int", dev_int, 1);
    cmd(8'hFE);
    rd(8'hFE, 8'h1D, "R8 status suspend reset");
    drain();
    cmd(8'hFE);
    rd(8'hFE, 8'h05, "R9 level bits kept");
    drain();

    cmd(8'hFF);
    rd(8'hFF, 8'h00, "R11 no error");
    drain();
    @(negedge clk);
    err_evt = 8'h24;
    @(negedge clk);
    err_evt = 8'h00;
    cmd(8'hFF);
    rd(8'hFF, 8'h13, "R11 code crc");
    drain();
    cmd(8'hFB);
    rd(8'hFF, 8'h00, "R12 mismatch keeps errors");
    rd(8'hFB, 8'h24, "R10 error status");
    drain();
    cmd(8'hFB);
    rd(8'hFB, 8'h00, "R10 cleared on read");
    drain();

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule